// File: doc/BRIEF.md
# Prioritised GPIO Interrupt Offset Encoder

This block watches the pins of two 8-bit general-purpose ports, turns a configured edge on any pin into a latched interrupt flag, and sorts the pending flags onto two request levels, high and low. For each level it presents a small offset value. Software reads that value to learn which pin to service first.

The offset is the pin index plus one, and zero means the level is idle. Port A pins take indices 0 to 7 and port B pins take indices 8 to 15. The lowest index always wins. Strobing a level's read input clears the flag that the level's offset is naming at that moment. A handler can therefore read offsets in a loop until it sees zero. Flags can also be cleared directly by writing ones to a clear mask.

Top module: `pio_irq_prio_enc`

## Requirements
- R1: While reset is asserted and right after it is released, all flags are clear, both offsets read 0 and both request outputs are low.
- R2: An offset of 0 means nothing is pending on that level. A non-zero offset k names pin k-1. Bit i of `pins_in` is pin i, so offsets 1–8 are port A pins 0–7 and offsets 9–16 are port B pins 0–7.
- R3: When several enabled flags are pending on one level, that level's offset names the lowest pin index.
- R4: `lvl_sel` bit i = 1 routes pin i to the high level and 0 routes it to the low level. Each request output is high exactly when its level has an enabled pending flag, which is also when its offset is non-zero.
- R5: Each pin passes through a two-flop synchroniser. A flag is set on the third rising clock edge after the pin changes, and only on the configured edge: `edge_rise` bit 1 selects rising and 0 selects falling. The opposite edge sets nothing. An edge on a pin whose `irq_en` bit is 0 sets nothing.
- R6: When `rd_hi` or `rd_lo` is high in a cycle, the flag named by that level's offset in that cycle is cleared at the next edge. A read strobe while the offset is 0 has no effect.
- R7: When `clr_we` is high, each `clr_mask` bit that is 1 clears that flag, and each bit that is 0 leaves its flag unchanged.
- R8: Clearing an `irq_en` bit hides a pending flag from the offsets and request outputs without erasing it. Setting the bit again brings the flag back.
- R9: If a new edge on a pin and a clear of that same pin fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pins_in | input | 16 | Raw pin levels, port A in bits 7:0, port B in bits 15:8 |
| irq_en | input | 16 | Per-pin interrupt enable |
| lvl_sel | input | 16 | Per-pin level: 1 high, 0 low |
| edge_rise | input | 16 | Per-pin edge: 1 rising, 0 falling |
| clr_we | input | 1 | Write strobe for the clear mask |
| clr_mask | input | 16 | Write-1-to-clear flag mask |
| rd_hi | input | 1 | Read strobe for the high-level offset |
| rd_lo | input | 1 | Read strobe for the low-level offset |
| irq_hi | output | 1 | High-level request |
| irq_lo | output | 1 | Low-level request |
| off_hi | output | 5 | High-level offset |
| off_lo | output | 5 | Low-level offset |

## Verification
Two functions can act on one flag in the same cycle: a newly arriving synchronised edge setting it, and a read strobe clearing it. The bench provokes this by timing the read strobe to fall in the cycle between the second and third clock edges after the pin toggles. That is the cycle in which the synchroniser output shows the edge. The result is judged by the offset still naming that pin afterwards, and by a second read then clearing it to zero.

// File: rtl/pio_irq_pkg.sv
// Shared definitions for the pin interrupt offset encoder.
// Assumes exactly two request levels, indexed by the enum below.
package pio_irq_pkg;
    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } irq_level_e;

    localparam int NUM_LEVELS = 2;
endpackage

// File: rtl/pio_pin_edge.sv
// Synchronises raw pin levels through two flops and reports one-cycle
// edge events of the per-pin selected polarity.
// Assumes pins are asynchronous to clk and reset is synchronous active low.
module pio_pin_edge #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    input  logic [N-1:0] rise_sel_i,
    output logic [N-1:0] event_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] last_q;

    // Two-flop synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= pins_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Per-pin polarity choice between rising and falling event.
    for (genvar g = 0; g < N; g++) begin : g_pin
        assign event_o[g] = rise_sel_i[g] ? (sync_q[g] & ~last_q[g])
                                          : (~sync_q[g] & last_q[g]);
    end
endmodule

// File: rtl/pio_flag_bank.sv
// Holds the latched interrupt flags. A set and a clear of the same bit
// in one cycle leave the bit set so no event is lost.
// Assumes set and clear vectors are already qualified by the caller.
module pio_flag_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    // Flag update with set taking precedence over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/pio_prio_offset.sv
// Fixed-priority encoder: returns lowest set index plus one, or zero.
// Assumes OW is wide enough to hold N.
module pio_prio_offset #(
    parameter int N  = 16,
    parameter int OW = 5
) (
    input  logic [N-1:0]  req_i,
    output logic [OW-1:0] off_o
);
    // Scan downward so the lowest requesting index is written last.
    always_comb begin
        off_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) off_o = OW'(i + 1);
        end
    end
endmodule

// File: rtl/pio_irq_prio_enc.sv
// Top: edge capture, flag storage, per-level masking and offset encoding
// with read-to-clear. Pin index i is bit i of pins_in; ports are stacked
// with the first port in the low bits. Offsets are combinational from
// the flags; a read strobe clears the reported flag at the next edge.
module pio_irq_prio_enc
    import pio_irq_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 8,
    localparam int NPINS    = NUM_PORTS * PORT_W,
    localparam int OFF_W    = $clog2(NPINS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_in,
    input  logic [NPINS-1:0] irq_en,
    input  logic [NPINS-1:0] lvl_sel,
    input  logic [NPINS-1:0] edge_rise,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_mask,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic             irq_hi,
    output logic             irq_lo,
    output logic [OFF_W-1:0] off_hi,
    output logic [OFF_W-1:0] off_lo
);
    logic [NPINS-1:0] edge_vec;
    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] flags;
    logic [NPINS-1:0] lvl_req  [NUM_LEVELS];
    logic [OFF_W-1:0] off_arr  [NUM_LEVELS];
    logic [NPINS-1:0] rd_clr   [NUM_LEVELS];
    logic             rd_arr   [NUM_LEVELS];
    logic             irq_arr  [NUM_LEVELS];

    pio_pin_edge #(.N(NPINS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins_in),
        .rise_sel_i(edge_rise),
        .event_o   (edge_vec)
    );

    assign set_vec = edge_vec & irq_en;

    assign rd_arr[int'(LVL_LO)] = rd_lo;
    assign rd_arr[int'(LVL_HI)] = rd_hi;

    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
        // Enabled pending flags routed to this level.
        assign lvl_req[lv] = flags & irq_en &
                             ((lv == int'(LVL_HI)) ? lvl_sel : ~lvl_sel);
        assign irq_arr[lv] = |lvl_req[lv];

        pio_prio_offset #(.N(NPINS), .OW(OFF_W)) u_enc (
            .req_i(lvl_req[lv]),
            .off_o(off_arr[lv])
        );

        // Read strobe clears only the pin the offset names.
        for (genvar p = 0; p < NPINS; p++) begin : g_rdclr
            assign rd_clr[lv][p] = rd_arr[lv] && (off_arr[lv] == OFF_W'(p + 1));
        end
    end

    // Merge software mask clear with both read-to-clear vectors.
    always_comb begin
        clr_vec = clr_we ? clr_mask : '0;
        for (int lv = 0; lv < NUM_LEVELS; lv++) clr_vec = clr_vec | rd_clr[lv];
    end

    pio_flag_bank #(.N(NPINS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flags_o(flags)
    );

    assign irq_hi = irq_arr[int'(LVL_HI)];
    assign irq_lo = irq_arr[int'(LVL_LO)];
    assign off_hi = off_arr[int'(LVL_HI)];
    assign off_lo = off_arr[int'(LVL_LO)];
endmodule

// File: rtl/pio_irq_checker.sv
// Property checker for pio_irq_prio_enc, attached by bind below.
// Assumes the set vector it observes is the qualified edge event vector.
module pio_irq_checker #(
    parameter int NPINS = 16,
    parameter int OFF_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_hi,
    input logic             irq_hi,
    input logic             irq_lo,
    input logic [OFF_W-1:0] off_hi,
    input logic [OFF_W-1:0] off_lo,
    input logic [NPINS-1:0] set_vec
);
    logic hi_reset_hit;

    // True when the pin named by off_hi receives a new event this cycle.
    always_comb begin
        hi_reset_hit = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (off_hi == OFF_W'(i + 1) && set_vec[i]) hi_reset_hit = 1'b1;
        end
    end

    assert_irq_hi_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi == (off_hi != '0));

    assert_irq_lo_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo == (off_lo != '0));

    assert_off_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (off_hi <= OFF_W'(NPINS)) && (off_lo <= OFF_W'(NPINS)));

    assert_levels_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && irq_lo) |-> (off_hi != off_lo));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && off_hi != '0 && !hi_reset_hit) |=> (off_hi != $past(off_hi)));
endmodule

bind pio_irq_prio_enc pio_irq_checker #(.NPINS(NPINS), .OFF_W(OFF_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_hi  (rd_hi),
    .irq_hi (irq_hi),
    .irq_lo (irq_lo),
    .off_hi (off_hi),
    .off_lo (off_lo),
    .set_vec(set_vec)
);

// File: tb/tb_pio_irq_prio_enc.sv
module tb_pio_irq_prio_enc;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int OW = 5;

    typedef struct packed {
        logic [N-1:0]  en;
        logic [N-1:0]  lvl;
        logic [N-1:0]  rise;
        logic [N-1:0]  pat;
        logic [OW-1:0] exp_hi;
        logic [OW-1:0] exp_lo;
    } vec_t;

    // Toggle pattern bits from their idle level; expected offsets per level.
    localparam vec_t VECS [0:7] = '{
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0006, 5'd2,  5'd0},
        '{16'hFFFF, 16'h0000, 16'h0000, 16'h8100, 5'd0,  5'd9},
        '{16'hFFFF, 16'h00F0, 16'hFFFF, 16'h0031, 5'd5,  5'd1},
        '{16'hFF00, 16'hFFFF, 16'hFFFF, 16'h0101, 5'd9,  5'd0},
        '{16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001, 5'd1,  5'd0},
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h8000, 5'd16, 5'd0},
        '{16'hFFFF, 16'h5555, 16'hAAAA, 16'h0C00, 5'd11, 5'd12},
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFE, 5'd2,  5'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins_in = '0, irq_en = '0, lvl_sel = '0, edge_rise = '0;
    logic          clr_we = 1'b0;
    logic [N-1:0]  clr_mask = '0;
    logic          rd_hi = 1'b0, rd_lo = 1'b0;
    logic          irq_hi, irq_lo;
    logic [OW-1:0] off_hi, off_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pio_irq_prio_enc dut (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .irq_en(irq_en),
        .lvl_sel(lvl_sel), .edge_rise(edge_rise), .clr_we(clr_we),
        .clr_mask(clr_mask), .rd_hi(rd_hi), .rd_lo(rd_lo),
        .irq_hi(irq_hi), .irq_lo(irq_lo), .off_hi(off_hi), .off_lo(off_lo)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_mask = '1;
        tick(1);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    initial begin
        // R1: reset state
        tick(3);
        check("R1 off_hi in reset", off_hi, 0);
        check("R1 irq_hi in reset", irq_hi, 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 off_lo after reset", off_lo, 0);
        check("R1 irq_lo after reset", irq_lo, 0);

        // Table walk: R2 R3 R4 R5 encoding, priority, levels, polarity
        foreach (VECS[k]) begin
            irq_en = VECS[k].en; lvl_sel = VECS[k].lvl; edge_rise = VECS[k].rise;
            pins_in = ~VECS[k].rise;
            tick(4);
            clear_all();
            pins_in = ~VECS[k].rise ^ VECS[k].pat;
            tick(3);
            check($sformatf("R3 vec%0d off_hi", k), off_hi, VECS[k].exp_hi);
            check($sformatf("R2 vec%0d off_lo", k), off_lo, VECS[k].exp_lo);
            check($sformatf("R4 vec%0d irq_hi", k), irq_hi, int'(VECS[k].exp_hi != 0));
            check($sformatf("R4 vec%0d irq_lo", k), irq_lo, int'(VECS[k].exp_lo != 0));
        end

        // R6: read-to-clear walks the pending pins in priority order
        irq_en = '1; lvl_sel = '1; edge_rise = '1; pins_in = '0;
        tick(4);
        clear_all();
        pins_in = 16'h0209;
        tick(3);
        check("R6 first offset", off_hi, 1);
        rd_hi = 1'b1; tick(1); rd_hi = 1'b0;
        check("R6 after read one", off_hi, 4);
        rd_hi = 1'b1; tick(1); rd_hi = 1'b0;
        check("R6 after read two", off_hi, 10);
        rd_hi = 1'b1; tick(1); rd_hi = 1'b0;
        check("R6 after read three", off_hi, 0);
        check("R6 irq_hi drops", irq_hi, 0);
        rd_hi = 1'b1; tick(1); rd_hi = 1'b0;
        check("R6 read at zero", off_hi, 0);

        // R7: write-one-to-clear, zero bits untouched
        pins_in = '0;
        tick(4);
        clear_all();
        pins_in = 16'h0024;
        tick(3);
        check("R7 setup", off_hi, 3);
        clr_we = 1'b1; clr_mask = 16'h0004; tick(1); clr_we = 1'b0;
        check("R7 one bit cleared", off_hi, 6);
        clr_we = 1'b1; clr_mask = 16'h0000; tick(1); clr_we = 1'b0;
        check("R7 zero mask no effect", off_hi, 6);
        clr_we = 1'b1; clr_mask = 16'h0020; tick(1); clr_we = 1'b0;
        check("R7 last bit cleared", off_hi, 0);

        // R5: opposite edge sets nothing
        pins_in = '0;
        tick(4);
        check("R5 falling edge ignored", off_hi, 0);
        check("R5 falling edge no irq", irq_hi, 0);

        // R8: disable hides, re-enable restores
        pins_in = 16'h0080;
        tick(3);
        check("R8 pin 7 pending", off_hi, 8);
        irq_en = 16'hFF7F; tick(1);
        check("R8 masked offset", off_hi, 0);
        check("R8 masked irq", irq_hi, 0);
        irq_en = '1; tick(1);
        check("R8 restored", off_hi, 8);

        // R5: edge on disabled pin sets no flag
        irq_en = 16'hFFFD;
        pins_in = 16'h0082;
        tick(3);
        irq_en = '1; tick(1);
        check("R5 disabled edge not latched", off_hi, 8);

        // R4: moving a pending pin to the low level
        lvl_sel = 16'hFF7F; tick(1);
        check("R4 high empty after move", off_hi, 0);
        check("R4 low shows moved pin", off_lo, 8);
        check("R4 irq_lo after move", irq_lo, 1);

        // R9: new edge and read-clear of same pin in one cycle
        pins_in = 16'h0002;
        tick(4);
        check("R9 setup still pending", off_lo, 8);
        pins_in = 16'h0082;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd_lo = 1'b1;
        tick(1);
        rd_lo = 1'b0;
        check("R9 set wins", off_lo, 8);
        rd_lo = 1'b1; tick(1); rd_lo = 1'b0;
        check("R9 later read clears", off_lo, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule